// File: doc/BRIEF.md
# Divider Configuration Loader

This block keeps the settings that steer a clock synthesizer: a loop-divider modulus (`cfg_m`, 9 bits), an output-divider code (`cfg_n`, 2 bits) and a test-select code (`cfg_t`, 3 bits). Settings reach it by two routes. At power-up, a board strap or a controller drives the parallel pins `par_m`/`par_n` and releases the strobe `par_load`. Later, software can send a 14-bit frame over a three-wire serial port (`ser_data`, `ser_clk`, `ser_load`) to retune the synthesizer.

All strobes are asynchronous to `clk`. They pass through a synchronizer of `SYNC_STAGES` flops. The serial clock is edge-detected in the `clk` domain. Each configuration latch is modelled as a register that follows its source while its strobe is in the open level and holds while the strobe is in the closed level. The parallel route always wins over the serial one. None of the interfaces is a stream: there is no valid/ready pair and no back-pressure. Every pin is a plain level or strobe that the user must hold stable for several `clk` cycles around each edge.

A range flag reports any loop modulus that lies outside the band in which the loop can lock.

Top module: `divcfg_loader`

## Requirements
- R1: After reset, `cfg_m`, `cfg_n`, `cfg_t` and `shift_tail` are 0, and `m_out_of_range` is 1.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into a 14-bit register. `shift_tail` shows the bit that entered 14 edges earlier, that is, the first bit of the last complete frame.
- R3: A frame is sent in this order: test code bit 2 first, then bits 1 and 0, then output code bits 1 and 0, then modulus bits 8 down to 0. After 14 edges, a serial load places each field into `cfg_t`, `cfg_n` and `cfg_m`.
- R4: While `ser_load` is high and `par_load` is high, the outputs follow the shift register, so a further shift changes them.
- R5: After `ser_load` falls, the outputs hold even while new frames are shifted in.
- R6: While `par_load` is low, `cfg_m`/`cfg_n` follow `par_m`/`par_n`. After `par_load` rises, later changes on the pins have no effect.
- R7: A serial load has no effect while `par_load` is low.
- R8: While `par_load` is low, `cfg_t` is 0. It stays 0 after `par_load` rises until the next serial load.
- R9: `m_out_of_range` is 1 exactly when `cfg_m` is below 200 or above 400 (200 and 400 are in range).
- R10: `ser_data` activity without a rising `ser_clk` edge does not alter the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, rising edge shifts |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial latch strobe, open while high |
| par_load | input | 1 | Parallel latch strobe, open while low |
| par_m | input | 9 | Parallel loop modulus |
| par_n | input | 2 | Parallel output-divider code |
| cfg_m | output | 9 | Active loop modulus |
| cfg_n | output | 2 | Active output-divider code |
| cfg_t | output | 3 | Active test-select code |
| shift_tail | output | 1 | Oldest bit in the serial shift register |
| m_out_of_range | output | 1 | Active modulus outside 200..400 |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 9/2/3-bit field split, and the 200..400 lock window. With these widths, the full 14-bit frame and the exact window edges (199, 200, 400, 401) can be reached. Each stimulus is held for six `clk` cycles, which covers the synchronizer, the edge detector and the latch register. The scenarios cover the following:
- transparency and hold of the serial latch;
- the handover between the two routes, with the parallel route taking priority;
- the test-code clearing;
- stray data toggles that must not shift.

// File: rtl/divcfg_pkg.sv
`timescale 1ns/1ps
package divcfg_pkg;
  localparam int unsigned DEF_M_W  = 9;
  localparam int unsigned DEF_N_W  = 2;
  localparam int unsigned DEF_T_W  = 3;
  localparam int unsigned DEF_M_LO = 200;
  localparam int unsigned DEF_M_HI = 400;

  // index of each strobe inside the synchronized control vector
  typedef enum int unsigned {
    CTL_DATA = 0,
    CTL_SCLK = 1,
    CTL_SLD  = 2,
    CTL_PLD  = 3
  } ctl_idx_e;

  localparam int unsigned CTL_W = 4;
endpackage

// File: rtl/divcfg_sync.sv
`timescale 1ns/1ps
module divcfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/divcfg_shifter.sv
`timescale 1ns/1ps
module divcfg_shifter #(
  parameter int unsigned LEN = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           bit_in,
  output logic [LEN-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[LEN-2:0], bit_in};
  end
endmodule

// File: rtl/divcfg_latch.sv
`timescale 1ns/1ps
module divcfg_latch #(
  parameter int unsigned M_W = 9,
  parameter int unsigned N_W = 2,
  parameter int unsigned T_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_hi,
  input  logic           ser_open,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic [M_W-1:0] sr_m,
  input  logic [N_W-1:0] sr_n,
  input  logic [T_W-1:0] sr_t,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (!par_hi) begin
      // parallel route open: it wins, and the test code is cleared
      m_q <= par_m;
      n_q <= par_n;
      t_q <= '0;
    end else if (ser_open) begin
      m_q <= sr_m;
      n_q <= sr_n;
      t_q <= sr_t;
    end
  end
endmodule

// File: rtl/divcfg_range.sv
`timescale 1ns/1ps
module divcfg_range #(
  parameter int unsigned M_W = 9,
  parameter int unsigned LO  = 200,
  parameter int unsigned HI  = 400
) (
  input  logic [M_W-1:0] m,
  output logic           outside
);
  logic [31:0] m_ext;
  assign m_ext   = 32'(m);
  assign outside = (m_ext < LO) || (m_ext > HI);
endmodule

// File: rtl/divcfg_loader.sv
`timescale 1ns/1ps
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int unsigned M_W         = DEF_M_W,
  parameter int unsigned N_W         = DEF_N_W,
  parameter int unsigned T_W         = DEF_T_W,
  parameter int unsigned M_LO        = DEF_M_LO,
  parameter int unsigned M_HI        = DEF_M_HI,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           par_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_t,
  output logic           shift_tail,
  output logic           m_out_of_range
);
  localparam int unsigned FRAME_W = T_W + N_W + M_W;
  localparam int unsigned N_LSB   = M_W;
  localparam int unsigned T_LSB   = M_W + N_W;
  localparam logic [CTL_W-1:0] CTL_IDLE = CTL_W'(1) << CTL_PLD;

  logic [CTL_W-1:0]   ctl_raw, ctl_s;
  logic               sclk_q, sclk_rise;
  logic               par_hi_s, ser_open_s;
  logic [FRAME_W-1:0] sr_word;

  assign ctl_raw[CTL_DATA] = ser_data;
  assign ctl_raw[CTL_SCLK] = ser_clk;
  assign ctl_raw[CTL_SLD]  = ser_load;
  assign ctl_raw[CTL_PLD]  = par_load;

  divcfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= ctl_s[CTL_SCLK];
  end

  assign sclk_rise  = ctl_s[CTL_SCLK] & ~sclk_q;
  assign par_hi_s   = ctl_s[CTL_PLD];
  assign ser_open_s = ctl_s[CTL_SLD];

  divcfg_shifter #(.LEN(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
    .bit_in(ctl_s[CTL_DATA]), .word(sr_word)
  );

  divcfg_latch #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .par_hi(par_hi_s), .ser_open(ser_open_s),
    .par_m(par_m), .par_n(par_n),
    .sr_m(sr_word[M_W-1:0]),
    .sr_n(sr_word[T_LSB-1:N_LSB]),
    .sr_t(sr_word[FRAME_W-1:T_LSB]),
    .m_q(cfg_m), .n_q(cfg_n), .t_q(cfg_t)
  );

  divcfg_range #(.M_W(M_W), .LO(M_LO), .HI(M_HI)) u_range (
    .m(cfg_m), .outside(m_out_of_range)
  );

  assign shift_tail = sr_word[FRAME_W-1];
endmodule

// File: rtl/divcfg_loader_chk.sv
`timescale 1ns/1ps
module divcfg_loader_chk #(
  parameter int unsigned M_W     = 9,
  parameter int unsigned N_W     = 2,
  parameter int unsigned T_W     = 3,
  parameter int unsigned M_LO    = 200,
  parameter int unsigned M_HI    = 400,
  parameter int unsigned FRAME_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               par_hi,
  input logic               ser_open,
  input logic               sclk_rise,
  input logic [M_W-1:0]     par_m,
  input logic [FRAME_W-1:0] sr_word,
  input logic [M_W-1:0]     cfg_m,
  input logic [N_W-1:0]     cfg_n,
  input logic [T_W-1:0]     cfg_t,
  input logic               tail,
  input logic               flag
);
  assert_par_clears_t_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !par_hi |=> cfg_t == '0);

  assert_par_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !par_hi |=> cfg_m == $past(par_m));

  assert_ser_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_hi && ser_open) |=> cfg_m == $past(sr_word[M_W-1:0]));

  assert_hold_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_hi && !ser_open) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

  assert_tail_no_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(tail));

  assert_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> (32'(cfg_m) >= M_LO && 32'(cfg_m) <= M_HI));
endmodule

bind divcfg_loader divcfg_loader_chk #(
  .M_W(M_W), .N_W(N_W), .T_W(T_W), .M_LO(M_LO), .M_HI(M_HI), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .par_hi(par_hi_s), .ser_open(ser_open_s),
  .sclk_rise(sclk_rise), .par_m(par_m), .sr_word(sr_word),
  .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .tail(shift_tail),
  .flag(m_out_of_range)
);

// File: tb/test_divcfg_loader.sv
`timescale 1ns/1ps
module test_divcfg_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic       shift_tail, m_out_of_range;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divcfg_loader i_divcfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t),
    .shift_tail(shift_tail), .m_out_of_range(m_out_of_range)
  );

  task automatic settle(int n = 6);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b);
    ser_data = b; settle();
    ser_clk = 1'b1; settle();
    ser_clk = 1'b0; settle();
  endtask

  task automatic send_frame(logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_sload();
    ser_load = 1'b1; settle();
    ser_load = 1'b0; settle();
  endtask

  task automatic check_cfg(string req, int m, int n, int t);
    chk(req, int'(cfg_m), m);
    chk(req, int'(cfg_n), n);
    chk(req, int'(cfg_t), t);
  endtask

  // R1: reset state
  task automatic t_reset();
    check_cfg("R1", 0, 0, 0);
    chk("R1", int'(shift_tail), 0);
    chk("R1", int'(m_out_of_range), 1);
  endtask

  // R2, R3: full frame then serial load
  task automatic t_serial_frame();
    logic [13:0] w;
    w = {3'b101, 2'b10, 9'd300};
    send_frame(w);
    chk("R2", int'(shift_tail), 1);
    pulse_sload();
    check_cfg("R3", 300, 2, 5);
    chk("R9", int'(m_out_of_range), 0);
  endtask

  // R4: latch open while ser_load high follows a further shift
  task automatic t_transparent();
    logic [13:0] w, nw;
    w  = {3'b101, 2'b10, 9'd300};
    nw = {w[12:0], 1'b1};
    ser_load = 1'b1; settle();
    send_bit(1'b1);
    check_cfg("R4", int'(nw[8:0]), int'(nw[10:9]), int'(nw[13:11]));
    chk("R2", int'(shift_tail), int'(w[12]));
    ser_load = 1'b0; settle();
  endtask

  // R5: hold after close; R10: data toggles without clock edge do nothing
  task automatic t_hold_and_noedge();
    logic [13:0] w, nw, b;
    w  = {3'b101, 2'b10, 9'd300};
    nw = {w[12:0], 1'b1};
    b  = {3'b011, 2'b01, 9'd222};
    send_frame(b);
    check_cfg("R5", int'(nw[8:0]), int'(nw[10:9]), int'(nw[13:11]));
    chk("R2", int'(shift_tail), int'(b[13]));
    ser_data = 1'b1; settle(3);
    ser_data = 1'b0; settle(3);
    ser_data = 1'b1; settle(8);
    chk("R10", int'(shift_tail), 0);
    pulse_sload();
    check_cfg("R10", 222, 1, 3);
  endtask

  // R6, R8: parallel route
  task automatic t_parallel();
    par_m = 9'd350; par_n = 2'd3; par_load = 1'b0; settle();
    check_cfg("R8", 350, 3, 0);
    par_m = 9'd260; settle();
    chk("R6", int'(cfg_m), 260);
    par_load = 1'b1; settle();
    par_m = 9'd123; par_n = 2'd0; settle();
    check_cfg("R6", 260, 3, 0);
  endtask

  // R7: serial load blocked while parallel strobe low
  task automatic t_priority();
    send_frame({3'b110, 2'b00, 9'd380});
    par_m = 9'd210; par_n = 2'd1; par_load = 1'b0; settle();
    pulse_sload();
    check_cfg("R7", 210, 1, 0);
    par_load = 1'b1; settle();
    check_cfg("R7", 210, 1, 0);
    pulse_sload();
    check_cfg("R3", 380, 0, 6);
  endtask

  // R9: window bounds
  task automatic t_range();
    int vals [6] = '{199, 200, 400, 401, 0, 511};
    int exps [6] = '{1, 0, 0, 1, 1, 1};
    for (int i = 0; i < 6; i++) begin
      par_m = 9'(vals[i]); par_load = 1'b0; settle();
      par_load = 1'b1; settle();
      chk("R9", int'(cfg_m), vals[i]);
      chk("R9", int'(m_out_of_range), exps[i]);
    end
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_serial_frame();
    t_transparent();
    t_hold_and_noedge();
    t_parallel();
    t_priority();
    t_range();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule